// File: doc/BRIEF.md
# Peripheral Idle Handshake Controller

This controller sits between a power manager and a small peripheral that raises interrupts. The power manager asks the peripheral to go into a low-power state by raising an idle request. The controller answers with an idle acknowledge, or holds it back. The answer depends on a two-bit idle-policy field in a configuration register and on whether any of the peripheral's output interrupts are still pending. After the acknowledge, the power manager may cut the peripheral's clock at its source. A status output tells the rest of the module whether it can still be accessed.

The same register holds an automatic-gating enable bit. When that bit is set and the register bus is quiet, a local clock-enable output goes low so that an external gating cell can stop the internal clock. When a bus access appears, the enable returns high in the same cycle, so the access is not delayed. The register is read and written through a simple single-cycle bus.

Top module: `idle_hshk_ctrl`

## Requirements
- R1: The configuration register sits at byte offset CFG_ADDR (default 0x08). A read there returns the policy field in bits [4:3] and the automatic-gating enable in bit 0, and every other bit reads as zero. A read at any other offset returns zero, and a write to any other offset changes nothing. Read data is combinational while bus_sel=1 and bus_we=0.
- R2: After reset the policy field is 00, the gating enable is 0, idle_ack is 0, mod_accessible is 1 and clk_en is 1.
- R3: With policy 00 (force), the first clock edge that samples idle_req=1 makes idle_ack go high, whatever irq_pend holds.
- R4: With policy 01 (no-idle), idle_ack never goes high.
- R5: The reserved policy 11 behaves exactly like no-idle: idle_ack never goes high.
- R6: With policy 10 (smart), idle_ack goes high after the first clock edge that samples idle_req=1 together with irq_pend all zero. While any irq_pend bit is set, idle_ack stays low.
- R7: idle_ack falls in the same cycle that idle_req falls, and the controller returns to the active state.
- R8: If idle_req falls while smart policy is still waiting for interrupts, the wait is abandoned without an acknowledge. When the request is raised again later, idle_ack cannot appear in the same cycle as that new request.
- R9: mod_accessible is low exactly while idle_ack is high.
- R10: clk_en is low only while the gating enable is 1 and bus_sel is 0. A cycle with bus_sel=1 has clk_en high in that same cycle.
- R11: A configuration write in the same cycle as an idle decision does not affect that decision. The decision uses the policy held before the write, and the new policy applies from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe; also the activity indication |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (zero when not reading the register) |
| irq_pend | input | IRQ_N | Peripheral output interrupts still asserted |
| idle_req | input | 1 | Low-power request from the power manager |
| idle_ack | output | 1 | Idle acknowledge to the power manager |
| mod_accessible | output | 1 | High unless in the acknowledged-idle state |
| clk_en | output | 1 | Enable for the external local clock gate |

## Verification
Two functions can fall in the same cycle: a register write that changes the idle policy, and the clock edge on which the handshake machine decides whether to acknowledge. The bench provokes this by driving a write that switches no-idle to force in the same cycle that idle_req rises. The acknowledge must then be absent after the first edge and present after the second. A second collision is a bus access during automatic gating: the bus access and the gate-enable decision fall in the same cycle, and clk_en is checked within that cycle for every combination of the enable bit and bus_sel.

// File: rtl/idlh_pkg.sv
package idlh_pkg;

  typedef enum logic [1:0] {
    MODE_FORCE = 2'b00,
    MODE_NONE  = 2'b01,
    MODE_SMART = 2'b10,
    MODE_RSVD  = 2'b11
  } idle_mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_WAIT = 2'b01,
    ST_IDLE = 2'b10
  } hs_state_e;

  localparam int MODE_LSB = 3;
  localparam int AUTO_BIT = 0;

  // Decision: may the block enter idle now, given policy and pending interrupts?
  function automatic logic may_idle(idle_mode_e m, logic irq_any);
    case (m)
      MODE_FORCE: may_idle = 1'b1;
      MODE_SMART: may_idle = ~irq_any;
      default:    may_idle = 1'b0;
    endcase
  endfunction

  // Policy that holds off the acknowledge only because interrupts are pending
  function automatic logic must_wait(idle_mode_e m, logic irq_any);
    must_wait = (m == MODE_SMART) && irq_any;
  endfunction

endpackage

// File: rtl/idlh_cfg_reg.sv
module idlh_cfg_reg
  import idlh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output idle_mode_e        mode_q,
  output logic              auto_q,
  output logic              cfg_wr_hit
);

  logic hit;
  logic wdata_unused;

  assign hit          = sel && (addr == CFG_ADDR);
  assign cfg_wr_hit   = hit && we;
  assign wdata_unused = &{1'b0, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_FORCE;
      auto_q <= 1'b0;
    end else if (cfg_wr_hit) begin
      mode_q <= idle_mode_e'(wdata[MODE_LSB +: 2]);
      auto_q <= wdata[AUTO_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit && !we) begin
      rdata[MODE_LSB +: 2] = mode_q;
      rdata[AUTO_BIT]      = auto_q;
    end
  end

endmodule

// File: rtl/idlh_fsm.sv
module idlh_fsm
  import idlh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  idle_mode_e mode,
  input  logic       irq_any,
  output hs_state_e  state_q,
  output logic       idle_ack,
  output logic       grant_evt,
  output logic       abandon_evt
);

  hs_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN, ST_WAIT: begin
        if (!idle_req)                  state_d = ST_RUN;
        else if (may_idle(mode, irq_any)) state_d = ST_IDLE;
        else if (must_wait(mode, irq_any)) state_d = ST_WAIT;
        else                            state_d = ST_RUN;
      end
      ST_IDLE: if (!idle_req) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign grant_evt   = (state_q != ST_IDLE) && (state_d == ST_IDLE);
  assign abandon_evt = (state_q == ST_WAIT) && !idle_req;
  assign idle_ack    = (state_q == ST_IDLE) && idle_req;

endmodule

// File: rtl/idlh_autogate.sv
module idlh_autogate (
  input  logic auto_en,
  input  logic bus_act,
  output logic clk_en
);

  assign clk_en = !auto_en || bus_act;

endmodule

// File: rtl/idle_hshk_ctrl.sv
module idle_hshk_ctrl
  import idlh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IRQ_N-1:0]  irq_pend,
  input  logic              idle_req,
  output logic              idle_ack,
  output logic              mod_accessible,
  output logic              clk_en
);

  idle_mode_e mode_q;
  logic       auto_q;
  logic       cfg_wr_hit;
  logic       irq_any;
  hs_state_e  state_q;
  logic       grant_evt;
  logic       abandon_evt;

  assign irq_any = |irq_pend;

  idlh_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mode_q(mode_q), .auto_q(auto_q),
    .cfg_wr_hit(cfg_wr_hit)
  );

  idlh_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .mode(mode_q),
    .irq_any(irq_any), .state_q(state_q), .idle_ack(idle_ack),
    .grant_evt(grant_evt), .abandon_evt(abandon_evt)
  );

  idlh_autogate u_gate (
    .auto_en(auto_q), .bus_act(bus_sel), .clk_en(clk_en)
  );

  assign mod_accessible = !idle_ack;

endmodule

// File: rtl/idlh_chk.sv
module idlh_chk
  import idlh_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       idle_req,
  input logic       idle_ack,
  input logic       mod_accessible,
  input logic       clk_en,
  input logic       bus_sel,
  input logic       auto_q,
  input idle_mode_e mode_q,
  input logic       irq_any,
  input logic       cfg_wr_hit,
  input logic       abandon_evt,
  input logic       grant_evt
);

  // R3 R4 R5 R6 R11
  ack_rise_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_ack) |-> ($past(mode_q) == MODE_FORCE ||
                         ($past(mode_q) == MODE_SMART && !$past(irq_any))));

  // R7
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |-> !idle_ack);

  // R8
  abandon_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_evt |=> !idle_ack);

  // R9
  access_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_accessible != idle_ack);

  // R10
  bus_wakes_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> clk_en);

  // R10
  quiet_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && !bus_sel) |-> !clk_en);

  // R6
  grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |-> idle_req);

  // R1
  cfg_write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_hit |-> bus_sel);

endmodule

bind idle_hshk_ctrl idlh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_ack(idle_ack),
  .mod_accessible(mod_accessible), .clk_en(clk_en), .bus_sel(bus_sel),
  .auto_q(auto_q), .mode_q(mode_q), .irq_any(irq_any),
  .cfg_wr_hit(cfg_wr_hit), .abandon_evt(abandon_evt), .grant_evt(grant_evt)
);

// File: tb/idle_hshk_ctrl_tb.sv
`timescale 1ns/1ps
module idle_hshk_ctrl_tb;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IRQ_N  = 4;
  localparam logic [7:0] CFG = 8'h08;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [IRQ_N-1:0]  irq_pend = '0;
  logic              idle_req = 1'b0;
  logic              idle_ack;
  logic              mod_accessible;
  logic              clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idle_hshk_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_N(IRQ_N), .CFG_ADDR(CFG)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
    .idle_req(idle_req), .idle_ack(idle_ack), .mod_accessible(mod_accessible),
    .clk_en(clk_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected acknowledge for a policy and interrupt set, from the requirements
  function automatic logic exp_ack(int m, int irq);
    if (m == 0) return 1'b1;
    if (m == 2) return (irq == 0);
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_image(logic [31:0] w);
    return {27'd0, w[4:3], 2'b00, w[0]};
  endfunction

  // All tasks start and end at a falling edge
  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    bus_rd(CFG, rd);
    chk("R2 cfg after reset", rd, 32'h0);
    chk("R2 idle_ack", {31'd0, idle_ack}, 32'd0);
    chk("R2 mod_accessible", {31'd0, mod_accessible}, 32'd1);
    chk("R2 clk_en", {31'd0, clk_en}, 32'd1);

    // R1 register image and decoding
    for (int k = 0; k < 16; k++) begin
      logic [31:0] w;
      w = 32'hA5C3_0F00 ^ (32'h0111_1111 * k) ^ 32'(k);
      bus_wr(CFG, w);
      bus_rd(CFG, rd);
      chk("R1 readback", rd, exp_image(w));
      bus_wr(CFG + 8'h04, ~w);
      bus_rd(CFG, rd);
      chk("R1 other-offset write ignored", rd, exp_image(w));
      bus_rd(CFG + 8'h04, rd);
      chk("R1 other-offset read zero", rd, 32'h0);
    end
    bus_wr(CFG, 32'h0);

    // R3 R4 R5 R6 R7 R9 sweep over policy and interrupt patterns
    for (int m = 0; m < 4; m++) begin
      for (int irq = 0; irq < 16; irq++) begin
        string tag;
        case (m)
          0: tag = "R3";
          1: tag = "R4";
          2: tag = "R6";
          default: tag = "R5";
        endcase
        bus_wr(CFG, 32'(m) << 3);
        irq_pend = 4'(irq);
        idle_req = 1'b1;
        #1 chk({tag, " no ack in request cycle"}, {31'd0, idle_ack}, 32'd0);
        @(negedge clk);
        chk({tag, " ack after edge"}, {31'd0, idle_ack}, {31'd0, exp_ack(m, irq)});
        chk("R9 status", {31'd0, mod_accessible}, {31'd0, !exp_ack(m, irq)});
        if (m == 2 && irq != 0) begin
          irq_pend = '0;
          @(negedge clk);
          chk("R6 ack after interrupts cleared", {31'd0, idle_ack}, 32'd1);
        end
        @(negedge clk);
        idle_req = 1'b0;
        #1;
        chk("R7 ack drops with request", {31'd0, idle_ack}, 32'd0);
        chk("R7 accessible again", {31'd0, mod_accessible}, 32'd1);
        @(negedge clk);
        irq_pend = '0;
      end
    end

    // R8 abandon the smart wait
    bus_wr(CFG, 32'h10);
    irq_pend = 4'b0100;
    idle_req = 1'b1;
    @(negedge clk);
    chk("R8 waiting", {31'd0, idle_ack}, 32'd0);
    idle_req = 1'b0;
    @(negedge clk);
    irq_pend = '0;
    @(negedge clk);
    chk("R8 no ack after abandon", {31'd0, idle_ack}, 32'd0);
    idle_req = 1'b1;
    #1 chk("R8 no instant ack on re-request", {31'd0, idle_ack}, 32'd0);
    @(negedge clk);
    chk("R8 fresh ack", {31'd0, idle_ack}, 32'd1);
    idle_req = 1'b0;
    @(negedge clk);

    // R11 write collides with decision
    bus_wr(CFG, 32'h08);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = CFG; bus_wdata = 32'h0;
    idle_req = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R11 old policy used", {31'd0, idle_ack}, 32'd0);
    @(negedge clk);
    chk("R11 new policy next edge", {31'd0, idle_ack}, 32'd1);
    idle_req = 1'b0;
    @(negedge clk);

    // R10 clock enable sweep
    for (int a = 0; a < 2; a++) begin
      bus_wr(CFG, 32'(a));
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 2; w++) begin
          bus_sel = s[0]; bus_we = w[0]; bus_addr = 8'h40;
          #1 chk("R10 clk_en", {31'd0, clk_en}, {31'd0, (a == 0) || (s == 1)});
          @(negedge clk);
        end
      end
      bus_sel = 1'b0; bus_we = 1'b0;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule